// File: doc/BRIEF.md
# Edge Change Detection Interrupt Unit

This block watches a parallel digital input port for level changes and raises an interrupt towards a host processor. Every input lane has its own rising-edge enable and its own falling-edge enable. An enabled transition latches sticky status flags: one per polarity, one for "any enabled edge", and one for an overflow that marks further enabled edges arriving while the interrupt is already active. A single-cycle expiry pulse from an external watchdog latches a watchdog flag of its own.

The interrupt output is the master enable ANDed with the OR of the latched rising, falling and watchdog flags, each gated by its own source enable. The host reaches the block through a flat register port with a write strobe, a write address, a read address and a combinational read path. The host selects how inputs are captured. In direct capture, the default after reset, each lane is sampled once, so pulses that span one clock edge are kept and the reaction is fast. In synchronized capture, each lane passes through a two-flop synchronizer before the edge compare.

Register addresses: 0 is the rising-edge enable mask, 1 is the falling-edge enable mask, 2 is control, 3 is status (read only) and 4 is clear (write only, write one to act).

Top module: `edci_top`

## Requirements
- R1: After reset the rising mask, falling mask, control and status registers all read 0, the interrupt output is low, and direct capture is selected (control bit 4 = 0).
- R2: A 0-to-1 transition on a lane whose bit is set in the rising mask (address 0) sets status bit 3, whatever the interrupt enables hold. A transition on a lane whose mask bit is clear changes no status bit.
- R3: A 1-to-0 transition on a lane whose bit is set in the falling mask (address 1) sets status bit 4, whatever the interrupt enables hold. A transition on a lane whose mask bit is clear changes no status bit.
- R4: Status bit 0 sets on any enabled transition of either polarity. It is set whenever status bit 3 or bit 4 is set.
- R5: Status bit 1 (overflow) sets when an enabled transition is detected while the interrupt output is already high. The transition that first raises the interrupt does not set it.
- R6: The interrupt output equals control bit 0 (master) AND the OR of: control bit 1 with status bit 3, control bit 2 with status bit 4, and control bit 3 with status bit 5. Status bit 2 reads the interrupt output.
- R7: A one-cycle watchdog expiry pulse sets status bit 5. Only writing 1 to clear bit 1 (address 4) clears it.
- R8: Writing 1 to clear bit 0 clears status bits 0, 1, 3 and 4 together and leaves bit 5 unchanged. An enabled transition detected in the same cycle as the clear wins, and its flags remain set.
- R9: In direct capture, a flag is readable on the second falling clock edge after the input change. In synchronized capture (control bit 4 = 1), it is readable on the third. In direct capture, a high pulse spanning one rising clock edge latches both polarities on a lane that has both enabled.
- R10: The masks read back as written. Control reads back its five low bits, with the upper bits 0. Status bits 6 and up always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_i | input | WIDTH | Monitored input lanes |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | WIDTH | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | WIDTH | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with WIDTH = 8, SYNC_STAGES = 2 and ADDR_W = 3. These values cover a full byte of lanes, so lanes inside and outside a mask can be exercised side by side: the low nibble against the high nibble, and single lanes such as 2, 4, 5 and 7. With two synchronizer stages, the latency gap between direct and synchronized capture is exactly one clock, which the bench measures edge by edge.

// File: rtl/edci_pkg.sv
`timescale 1ns/1ps
package edci_pkg;
    localparam int REG_RISE = 0;
    localparam int REG_FALL = 1;
    localparam int REG_CTRL = 2;
    localparam int REG_STAT = 3;
    localparam int REG_CLR  = 4;

    // control register, bit 0 = master ... bit 4 = sync_mode
    typedef struct packed {
        logic sync_mode;
        logic wdt_ie;
        logic fall_ie;
        logic rise_ie;
        logic master;
    } ctrl_t;

    // sticky flags
    typedef struct packed {
        logic edge_seen;
        logic ovf;
        logic rise;
        logic fall;
        logic wdt;
    } flags_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = 6;
endpackage

// File: rtl/edci_capture.sv
`timescale 1ns/1ps
module edci_capture
    import edci_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] port_i,
    input  logic             sync_mode_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    output logic [WIDTH-1:0] rise_hit_o,
    output logic [WIDTH-1:0] fall_hit_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]                  prev;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [WIDTH-1:0] sel;

    always_comb begin
        cap_d          = cap_q;
        sel            = sync_mode_i ? cap_q.chain[LAST] : cap_q.chain[0];
        cap_d.chain[0] = port_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            cap_d.chain[s] = cap_q.chain[s-1];
        end
        cap_d.prev = sel;
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_lane
            assign rise_hit_o[b] = rise_en_i[b] &  sel[b] & ~cap_q.prev[b];
            assign fall_hit_o[b] = fall_en_i[b] & ~sel[b] &  cap_q.prev[b];
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end
endmodule

// File: rtl/edci_status.sv
`timescale 1ns/1ps
module edci_status
    import edci_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] rise_hit_i,
    input  logic [WIDTH-1:0] fall_hit_i,
    input  logic             wdt_pulse_i,
    input  logic             clr_edge_i,
    input  logic             clr_wdt_i,
    input  ctrl_t            ctrl_i,
    output flags_t           flags_o,
    output logic             irq_o
);
    flags_t fl_d, fl_q;
    logic any_rise, any_fall, irq;

    always_comb begin
        any_rise = |rise_hit_i;
        any_fall = |fall_hit_i;
        irq = ctrl_i.master & ((ctrl_i.rise_ie & fl_q.rise) |
                               (ctrl_i.fall_ie & fl_q.fall) |
                               (ctrl_i.wdt_ie  & fl_q.wdt));
        fl_d = fl_q;
        if (clr_edge_i) begin
            fl_d.edge_seen = 1'b0;
            fl_d.ovf       = 1'b0;
            fl_d.rise      = 1'b0;
            fl_d.fall      = 1'b0;
        end
        if (clr_wdt_i) fl_d.wdt = 1'b0;
        // new events take priority over a clear in the same cycle
        if (any_rise) fl_d.rise = 1'b1;
        if (any_fall) fl_d.fall = 1'b1;
        if (any_rise | any_fall) fl_d.edge_seen = 1'b1;
        if ((any_rise | any_fall) & irq) fl_d.ovf = 1'b1;
        if (wdt_pulse_i) fl_d.wdt = 1'b1;
    end

    assign flags_o = fl_q;
    assign irq_o   = irq;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '0;
        else         fl_q <= fl_d;
    end
endmodule

// File: rtl/edci_regs.sv
`timescale 1ns/1ps
module edci_regs
    import edci_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  flags_t            flags_i,
    input  logic              irq_i,
    output logic [WIDTH-1:0]  rise_en_o,
    output logic [WIDTH-1:0]  fall_en_o,
    output ctrl_t             ctrl_o,
    output logic              clr_edge_o,
    output logic              clr_wdt_o,
    output logic [WIDTH-1:0]  rd_data_o
);
    typedef struct packed {
        logic [WIDTH-1:0] rise_en;
        logic [WIDTH-1:0] fall_en;
        ctrl_t            ctrl;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [STAT_W-1:0] stat_view;

    always_comb begin
        rg_d       = rg_q;
        clr_edge_o = 1'b0;
        clr_wdt_o  = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_W'(REG_RISE): rg_d.rise_en = wr_data_i;
                ADDR_W'(REG_FALL): rg_d.fall_en = wr_data_i;
                ADDR_W'(REG_CTRL): rg_d.ctrl    = ctrl_t'(wr_data_i[CTRL_W-1:0]);
                ADDR_W'(REG_CLR): begin
                    clr_edge_o = wr_data_i[0];
                    clr_wdt_o  = wr_data_i[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        stat_view = {flags_i.wdt, flags_i.fall, flags_i.rise,
                     irq_i, flags_i.ovf, flags_i.edge_seen};
        case (rd_addr_i)
            ADDR_W'(REG_RISE): rd_data_o = rg_q.rise_en;
            ADDR_W'(REG_FALL): rd_data_o = rg_q.fall_en;
            ADDR_W'(REG_CTRL): rd_data_o = WIDTH'(rg_q.ctrl);
            ADDR_W'(REG_STAT): rd_data_o = WIDTH'(stat_view);
            default:           rd_data_o = '0;
        endcase
    end

    assign rise_en_o = rg_q.rise_en;
    assign fall_en_o = rg_q.fall_en;
    assign ctrl_o    = rg_q.ctrl;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rg_q <= '0;
        else         rg_q <= rg_d;
    end
endmodule

// File: rtl/edci_top.sv
`timescale 1ns/1ps
module edci_top
    import edci_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WIDTH-1:0]  port_i,
    input  logic              wdt_expire_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WIDTH-1:0]  rd_data_o,
    output logic              irq_o
);
    logic [WIDTH-1:0] rise_en_w, fall_en_w, rise_hit_w, fall_hit_w;
    ctrl_t            ctrl_w;
    flags_t           flags_w;
    logic             clr_edge_w, clr_wdt_w, irq_w;

    edci_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .flags_i(flags_w), .irq_i(irq_w),
        .rise_en_o(rise_en_w), .fall_en_o(fall_en_w), .ctrl_o(ctrl_w),
        .clr_edge_o(clr_edge_w), .clr_wdt_o(clr_wdt_w), .rd_data_o(rd_data_o)
    );

    edci_capture #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk_i(clk_i), .rst_ni(rst_ni), .port_i(port_i),
        .sync_mode_i(ctrl_w.sync_mode),
        .rise_en_i(rise_en_w), .fall_en_i(fall_en_w),
        .rise_hit_o(rise_hit_w), .fall_hit_o(fall_hit_w)
    );

    edci_status #(.WIDTH(WIDTH)) u_stat (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .rise_hit_i(rise_hit_w), .fall_hit_i(fall_hit_w),
        .wdt_pulse_i(wdt_expire_i),
        .clr_edge_i(clr_edge_w), .clr_wdt_i(clr_wdt_w),
        .ctrl_i(ctrl_w), .flags_o(flags_w), .irq_o(irq_w)
    );

    assign irq_o = irq_w;
endmodule

// File: rtl/edci_checker.sv
`timescale 1ns/1ps
module edci_checker #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              irq_o,
    input logic              master,
    input logic              any_rise,
    input logic              any_hit,
    input logic              clr_edge,
    input logic              wdt_pulse,
    input logic              edge_st,
    input logic              ovf_st,
    input logic              rise_st,
    input logic              fall_st,
    input logic              wdt_st,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WIDTH-1:0]  rd_data
);
    AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> master); // R6
    AST_RISE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_rise |=> rise_st); // R2
    AST_RISE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_st && !clr_edge) |=> rise_st); // R8
    AST_OVF_NEEDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_st) |-> $past(irq_o)); // R5
    AST_WDT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_pulse |=> wdt_st); // R7
    AST_CLEAR_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_edge && !any_hit) |=> (!edge_st && !ovf_st && !rise_st && !fall_st)); // R8
    AST_EDGE_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_st || fall_st) |-> edge_st); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr == ADDR_W'(3)) |-> (rd_data[WIDTH-1:6] == '0)); // R10
endmodule

bind edci_top edci_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .master(ctrl_w.master),
    .any_rise(|rise_hit_w), .any_hit((|rise_hit_w) | (|fall_hit_w)),
    .clr_edge(clr_edge_w), .wdt_pulse(wdt_expire_i),
    .edge_st(flags_w.edge_seen), .ovf_st(flags_w.ovf), .rise_st(flags_w.rise),
    .fall_st(flags_w.fall), .wdt_st(flags_w.wdt),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o)
);

// File: tb/tb_edci_top.sv
`timescale 1ns/1ps
module tb_edci_top;
    localparam int W = 8;
    localparam int AW = 3;
    localparam logic [7:0] S_EDGE = 8'h01, S_OVF = 8'h02, S_IRQ = 8'h04,
                           S_RISE = 8'h08, S_FALL = 8'h10, S_WDT = 8'h20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0] port = '0, wdata = '0, rdata;
    logic [AW-1:0] waddr = '0, raddr = '0;
    logic wen = 1'b0, wdt = 1'b0, irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edci_top #(.WIDTH(W), .SYNC_STAGES(2), .ADDR_W(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .port_i(port), .wdt_expire_i(wdt),
        .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
        .rd_addr_i(raddr), .rd_data_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        waddr = AW'(a); wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        raddr = AW'(a);
        #0.5;
        d = rdata;
    endtask

    task automatic chk_stat(input string req, input logic [7:0] exp);
        logic [W-1:0] v;
        rd(3, v);
        chk(req, v, exp);
    endtask

    task automatic quiet();
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
        port = '0; cyc(4);
        wr(4, 8'h03);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset irq", irq, 0);
    endtask

    task automatic t_rise();
        quiet();
        wr(0, 8'h0F);
        port = 8'h01; cyc(3);
        chk_stat("R2 enabled rise", S_RISE | S_EDGE);
        wr(4, 8'h01);
        port = 8'h81; cyc(3);
        chk_stat("R2 masked rise ignored", 8'h00);
    endtask

    task automatic t_fall();
        quiet();
        port = 8'h81; cyc(4);
        wr(1, 8'hF0);
        port = 8'h80; cyc(3);
        chk_stat("R3 masked fall ignored", 8'h00);
        port = 8'h00; cyc(3);
        chk_stat("R3 R4 enabled fall", S_FALL | S_EDGE);
    endtask

    task automatic t_irq_gate();
        // fall flag still set from previous task
        wr(2, 8'h04); cyc(1);
        chk("R6 no master", irq, 0);
        wr(2, 8'h05); cyc(1);
        chk("R6 master and fall enable", irq, 1);
        chk_stat("R6 status mirrors irq", S_FALL | S_EDGE | S_IRQ);
        wr(2, 8'h03); cyc(1);
        chk("R6 source not enabled", irq, 0);
    endtask

    task automatic t_overflow();
        quiet();
        wr(0, 8'h03); wr(2, 8'h03);
        port = 8'h01; cyc(3);
        chk_stat("R5 first edge no overflow", S_EDGE | S_RISE | S_IRQ);
        port = 8'h03; cyc(3);
        chk_stat("R5 edge while irq", S_EDGE | S_RISE | S_IRQ | S_OVF);
        wr(4, 8'h01); cyc(1);
        chk_stat("R8 clear group", 8'h00);
        chk("R6 irq drops after clear", irq, 0);
    endtask

    task automatic t_wdt();
        quiet();
        wdt = 1'b1; @(negedge clk); wdt = 1'b0; cyc(1);
        chk_stat("R7 watchdog flag", S_WDT);
        wr(2, 8'h09); cyc(1);
        chk("R7 R6 watchdog irq", irq, 1);
        wr(4, 8'h01); cyc(1);
        chk_stat("R8 group clear keeps watchdog", S_WDT | S_IRQ);
        wr(4, 8'h02); cyc(1);
        chk_stat("R7 watchdog clear", 8'h00);
    endtask

    task automatic t_clear_race();
        quiet();
        wr(0, 8'h04);
        port = 8'h04;
        @(negedge clk);
        wr(4, 8'h01);
        chk_stat("R8 edge beats clear", S_RISE | S_EDGE);
    endtask

    task automatic t_latency();
        quiet();
        wr(0, 8'h10);
        port = 8'h10;
        cyc(1); chk_stat("R9 direct one edge", 8'h00);
        cyc(1); chk_stat("R9 direct two edges", S_RISE | S_EDGE);
        quiet();
        wr(2, 8'h10); wr(0, 8'h10);
        port = 8'h10;
        cyc(2); chk_stat("R9 sync two edges", 8'h00);
        cyc(1); chk_stat("R9 sync three edges", S_RISE | S_EDGE);
        quiet();
        wr(0, 8'h20); wr(1, 8'h20);
        port = 8'h20; @(negedge clk); port = 8'h00;
        cyc(3);
        chk_stat("R9 short pulse both polarities", S_RISE | S_FALL | S_EDGE);
    endtask

    task automatic t_readback();
        logic [W-1:0] v;
        quiet();
        wr(0, 8'hA5); wr(1, 8'h5A); wr(2, 8'hFF);
        rd(0, v); chk("R10 rise mask", v, 8'hA5);
        rd(1, v); chk("R10 fall mask", v, 8'h5A);
        rd(2, v); chk("R10 control", v, 8'h1F);
        wdt = 1'b1; @(negedge clk); wdt = 1'b0; cyc(1);
        rd(3, v); chk("R10 status reserved", v & 8'hC0, 0);
        wr(2, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_rise();
        t_fall();
        t_irq_gate();
        t_overflow();
        t_wdt();
        t_clear_race();
        t_latency();
        t_readback();
        finish_run();
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        finish_run();
    end
endmodule